// File: doc/BRIEF.md
# Sprite Attribute Table DMA Engine

This engine moves a sprite attribute table held in video memory into the video chip's internal sprite attribute register file. The table is 64 sprites of four 16-bit words, 256 words in total. It may start at any word address, which the `baseAddr` input gives. A copy begins on the strobe marking the end of the display's active frame. That strobe is tied to the display timing set up in the video chip and need not line up with the television's vertical blank. A copy runs only when the auto-copy flag is set or a one-shot request is pending.

While a copy runs, the engine owns video memory and raises `cpuBlock` so the memory arbiter stalls the CPU. The copy advances one word per memory slot granted through `slotEn`, so its speed follows the dot clock that drives the slot pulses. CPU writes to the table in memory reach the register file only when a later copy reads them. When the last word has been written, `done` pulses and a served one-shot request is cleared.

Top module: `spriteTableDma`

## Requirements
- R1: After reset, `cpuBlock`, `done`, `memRdEn` and `sprWrEn` are low, no one-shot request is pending, and the engine is idle.
- R2: When idle with `autoMode` high, a `frameEnd` pulse raises `cpuBlock` on the next cycle and a copy begins.
- R3: A `oneShotReq` pulse followed by `frameEnd` with `autoMode` low starts exactly one copy. After that copy completes, a further `frameEnd` with `autoMode` low starts nothing.
- R4: A `frameEnd` pulse with `autoMode` low and no pending request leaves `cpuBlock` low and issues no memory read.
- R5: A copy reads the 256 addresses `base+0` through `base+255` in ascending order, with addition modulo 2^16. `base` is the `baseAddr` value captured at the start, and later changes to `baseAddr` do not affect the running copy.
- R6: Each word read at offset k is written, one cycle after `memRdData` returns it, to register index k, with the data the memory held when it was read.
- R7: A memory read is issued only in the cycle after `slotEn` was sampled high, and at most one read is issued per slot.
- R8: `cpuBlock` stays high from the cycle after the starting `frameEnd` through the cycle of the last register write. `done` is a single-cycle pulse in that last-write cycle. With `slotEn` held high, a copy holds `cpuBlock` for exactly 258 cycles.
- R9: A `frameEnd` that arrives while a copy is running is ignored: no restart, exactly 256 writes and one `done`.
- R10: A `oneShotReq` that arrives while a copy is running stays pending after that copy completes, and the next `frameEnd` starts a new copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| autoMode | input | 1 | Copy at every frame end |
| oneShotReq | input | 1 | Pulse: request one copy at the next frame end |
| baseAddr | input | 16 | Word address of the table in video memory |
| frameEnd | input | 1 | Pulse: the active frame has ended |
| slotEn | input | 1 | A memory slot is granted this cycle (dot-clock pacing) |
| memRdEn | output | 1 | Video memory read strobe |
| memRdAddr | output | 16 | Video memory read address |
| memRdData | input | 16 | Read data, valid the cycle after `memRdEn` |
| sprWrEn | output | 1 | Register file write strobe |
| sprWrIdx | output | 8 | Register file word index |
| sprWrData | output | 16 | Register file write data |
| cpuBlock | output | 1 | Copy in progress; the arbiter locks out the CPU |
| done | output | 1 | One-cycle pulse in the last write cycle |

## Verification
A `frameEnd` sampled at a clock edge shows up as `cpuBlock` one cycle later. A slot sampled at an edge produces `memRdEn` after that edge and the matching `sprWrEn` one edge later. `done` comes one cycle after the final read, and `cpuBlock` drops one cycle after that. The bench drives inputs just after the falling edge and samples all outputs at the falling edge, so each value is read half a cycle after the rising edge that set it. A monitor tracks the expected read address and write index against those latencies and counts busy cycles, which pins the 258-cycle hold at full slot rate.

// File: rtl/spriteDmaPkg.sv
package spriteDmaPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } dmaState_t;

  typedef struct packed {
    logic start;  // capture base, clear word counter
    logic issue;  // launch one read and advance the counter
  } dmaStrobes_t;

endpackage

// File: rtl/spriteDmaCtrl.sv
module spriteDmaCtrl
  import spriteDmaPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        autoMode,
  input  logic        oneShotReq,
  input  logic        frameEnd,
  input  logic        slotEn,
  input  logic        lastIssue,
  input  logic        lastWrite,
  output dmaStrobes_t strobes,
  output logic        cpuBlock,
  output logic        done
);

  dmaState_t state, stateNext;
  logic pending;
  logic reArm;
  logic startNow;
  logic finishNow;

  assign startNow  = (state == ST_IDLE) && frameEnd && (autoMode || pending);
  assign finishNow = (state == ST_DRAIN) && lastWrite;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (startNow) stateNext = ST_RUN;
      ST_RUN:   if (slotEn && lastIssue) stateNext = ST_DRAIN;
      ST_DRAIN: if (lastWrite) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // One-shot bookkeeping: a request seen while a copy runs survives its end.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
      reArm   <= 1'b0;
    end else begin
      if (finishNow)       pending <= reArm || oneShotReq;
      else if (oneShotReq) pending <= 1'b1;

      if (startNow)                            reArm <= oneShotReq;
      else if (finishNow)                      reArm <= 1'b0;
      else if (oneShotReq && state != ST_IDLE) reArm <= 1'b1;
    end
  end

  always_comb begin
    strobes.start = startNow;
    strobes.issue = (state == ST_RUN) && slotEn;
  end

  assign cpuBlock = (state != ST_IDLE);
  assign done     = finishNow;

endmodule

// File: rtl/spriteDmaPath.sv
module spriteDmaPath
  import spriteDmaPkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int TABLE_WORDS = 256,
  localparam int IDX_W      = $clog2(TABLE_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobes_t       strobes,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic              sprWrEn,
  output logic [IDX_W-1:0]  sprWrIdx,
  output logic [DATA_W-1:0] sprWrData,
  output logic              lastIssue,
  output logic              lastWrite
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TABLE_WORDS - 1);

  logic [ADDR_W-1:0] baseHeld;
  logic [IDX_W-1:0]  wordCnt;
  logic [IDX_W-1:0]  rdIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseHeld <= '0;
      wordCnt  <= '0;
    end else if (strobes.start) begin
      baseHeld <= baseAddr;
      wordCnt  <= '0;
    end else if (strobes.issue) begin
      wordCnt  <= wordCnt + 1'b1;
    end
  end

  // Read launch stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memRdEn   <= 1'b0;
      memRdAddr <= '0;
      rdIdx     <= '0;
    end else begin
      memRdEn <= strobes.issue;
      if (strobes.issue) begin
        memRdAddr <= baseHeld + ADDR_W'(wordCnt);
        rdIdx     <= wordCnt;
      end
    end
  end

  // Write stage: data comes back one cycle after the read strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sprWrEn  <= 1'b0;
      sprWrIdx <= '0;
    end else begin
      sprWrEn <= memRdEn;
      if (memRdEn) sprWrIdx <= rdIdx;
    end
  end

  assign sprWrData = memRdData;
  assign lastIssue = (wordCnt == LAST_IDX);
  assign lastWrite = sprWrEn && (sprWrIdx == LAST_IDX);

endmodule

// File: rtl/spriteTableDma.sv
module spriteTableDma
  import spriteDmaPkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int SPRITES     = 64,
  parameter int WORDS_PER   = 4,
  localparam int TABLE_WORDS = SPRITES * WORDS_PER,
  localparam int IDX_W       = $clog2(TABLE_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              autoMode,
  input  logic              oneShotReq,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              frameEnd,
  input  logic              slotEn,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              sprWrEn,
  output logic [IDX_W-1:0]  sprWrIdx,
  output logic [DATA_W-1:0] sprWrData,
  output logic              cpuBlock,
  output logic              done
);

  dmaStrobes_t strobes;
  logic lastIssue;
  logic lastWrite;

  spriteDmaCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .autoMode  (autoMode),
    .oneShotReq(oneShotReq),
    .frameEnd  (frameEnd),
    .slotEn    (slotEn),
    .lastIssue (lastIssue),
    .lastWrite (lastWrite),
    .strobes   (strobes),
    .cpuBlock  (cpuBlock),
    .done      (done)
  );

  spriteDmaPath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .TABLE_WORDS(TABLE_WORDS)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .baseAddr  (baseAddr),
    .memRdData (memRdData),
    .memRdEn   (memRdEn),
    .memRdAddr (memRdAddr),
    .sprWrEn   (sprWrEn),
    .sprWrIdx  (sprWrIdx),
    .sprWrData (sprWrData),
    .lastIssue (lastIssue),
    .lastWrite (lastWrite)
  );

endmodule

// File: rtl/spriteTableDmaChk.sv
module spriteTableDmaChk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             autoMode,
  input logic             frameEnd,
  input logic             slotEn,
  input logic             memRdEn,
  input logic             sprWrEn,
  input logic [IDX_W-1:0] sprWrIdx,
  input logic             cpuBlock,
  input logic             done
);

  p_start_auto_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuBlock && frameEnd && autoMode) |=> cpuBlock);

  p_rise_needs_frame_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuBlock) |-> $past(frameEnd));

  p_write_index_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sprWrEn && $past(sprWrEn)) |-> (sprWrIdx == $past(sprWrIdx) + 1'b1));

  p_write_after_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    sprWrEn |-> $past(memRdEn));

  p_read_needs_slot_r7: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> $past(slotEn));

  p_read_while_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> cpuBlock);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (cpuBlock && sprWrEn) ##1 !cpuBlock);

endmodule

bind spriteTableDma spriteTableDmaChk #(.IDX_W(IDX_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .autoMode(autoMode),
  .frameEnd(frameEnd),
  .slotEn  (slotEn),
  .memRdEn (memRdEn),
  .sprWrEn (sprWrEn),
  .sprWrIdx(sprWrIdx),
  .cpuBlock(cpuBlock),
  .done    (done)
);

// File: tb/tb_spriteTableDma.sv
`timescale 1ns/1ps
module tb_spriteTableDma;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        autoMode = 1'b0;
  logic        oneShotReq = 1'b0;
  logic [15:0] baseAddr = '0;
  logic        frameEnd = 1'b0;
  logic        slotEn = 1'b0;
  logic        memRdEn;
  logic [15:0] memRdAddr;
  logic [15:0] memRdData = '0;
  logic        sprWrEn;
  logic [7:0]  sprWrIdx;
  logic [15:0] sprWrData;
  logic        cpuBlock;
  logic        done;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  spriteTableDma dut (
    .clk(clk), .rstN(rstN), .autoMode(autoMode), .oneShotReq(oneShotReq),
    .baseAddr(baseAddr), .frameEnd(frameEnd), .slotEn(slotEn),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .sprWrEn(sprWrEn), .sprWrIdx(sprWrIdx), .sprWrData(sprWrData),
    .cpuBlock(cpuBlock), .done(done)
  );

  // Memory contents are a function of address and a salt the "CPU" changes.
  logic [15:0] salt = 16'h0000;
  always @(posedge clk) memRdData <= memRdEn ? (memRdAddr ^ salt) : 16'h0000;

  // Slot pacing: slot every (slotDiv) cycles
  int slotDiv = 1;
  int slotPhase = 0;
  always @(negedge clk) begin
    #1;
    slotPhase = (slotPhase + 1) % slotDiv;
    slotEn = (slotPhase == 0);
  end

  logic slotAtEdge = 1'b0;
  always @(posedge clk) slotAtEdge <= slotEn;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor
  bit          monOn = 1'b0;
  logic [15:0] expBase = '0;
  int rdCount, wrCount, doneCount, busyCount;

  task automatic resetMon(input logic [15:0] b);
    expBase = b; rdCount = 0; wrCount = 0; doneCount = 0; busyCount = 0;
  endtask

  always @(negedge clk) if (monOn) begin
    if (cpuBlock) busyCount++;
    if (done) doneCount++;
    if (memRdEn) begin
      check(slotAtEdge, "R7 read without slot", 32'(slotAtEdge), 32'd1);
      check(memRdAddr == 16'(expBase + rdCount), "R5 read address",
            32'(memRdAddr), 32'(16'(expBase + rdCount)));
      rdCount++;
    end
    if (sprWrEn) begin
      check(sprWrIdx == 8'(wrCount), "R6 write index", 32'(sprWrIdx), 32'(8'(wrCount)));
      check(sprWrData == (16'(expBase + wrCount) ^ salt), "R6 write data",
            32'(sprWrData), 32'(16'(expBase + wrCount) ^ salt));
      wrCount++;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic pulseFrame();
    @(negedge clk); #2 frameEnd = 1'b1;
    @(negedge clk); #2 frameEnd = 1'b0;
  endtask

  task automatic pulseReq();
    @(negedge clk); #2 oneShotReq = 1'b1;
    @(negedge clk); #2 oneShotReq = 1'b0;
  endtask

  task automatic waitDone();
    int guard = 0;
    while (doneCount == 0 && guard < 4000) begin
      @(negedge clk); guard++;
    end
    cyc(3);
  endtask

  task automatic checkFullCopy(input string req);
    check(rdCount == 256, req, 32'(rdCount), 32'd256);
    check(wrCount == 256, req, 32'(wrCount), 32'd256);
    check(doneCount == 1, req, 32'(doneCount), 32'd1);
  endtask

  task automatic t_reset();
    check(!cpuBlock && !done && !memRdEn && !sprWrEn, "R1 reset outputs",
          {28'd0, cpuBlock, done, memRdEn, sprWrEn}, 32'd0);
    resetMon(16'h0);
    pulseFrame();
    cyc(5);
    check(busyCount == 0, "R1 no pending after reset", 32'(busyCount), 32'd0);
  endtask

  task automatic t_idleFrame();
    autoMode = 1'b0;
    resetMon(16'h0);
    pulseFrame();
    cyc(10);
    check(busyCount == 0, "R4 busy", 32'(busyCount), 32'd0);
    check(rdCount == 0, "R4 reads", 32'(rdCount), 32'd0);
  endtask

  task automatic t_autoFull();
    slotDiv = 1; salt = 16'h5A5A; baseAddr = 16'h1000; autoMode = 1'b1;
    resetMon(16'h1000);
    @(negedge clk); #2 frameEnd = 1'b1;
    @(negedge clk);
    check(cpuBlock == 1'b1, "R2 busy one cycle after frame end", 32'(cpuBlock), 32'd1);
    #2 frameEnd = 1'b0;
    cyc(4); baseAddr = 16'h7777;     // R5: must not disturb the running copy
    waitDone();
    autoMode = 1'b0;
    checkFullCopy("R2 R5 R6 full copy");
    check(busyCount == 258, "R8 busy length", 32'(busyCount), 32'd258);
  endtask

  task automatic t_slowWrap();
    slotDiv = 3; salt = 16'h0F0F; baseAddr = 16'hFF80; autoMode = 1'b1;
    resetMon(16'hFF80);
    pulseFrame();
    autoMode = 1'b0;
    waitDone();
    checkFullCopy("R5 R7 wrapping slow copy");
    check(busyCount > 700, "R7 paced by slots", 32'(busyCount), 32'd700);
    slotDiv = 1;
  endtask

  task automatic t_oneShot();
    autoMode = 1'b0; baseAddr = 16'h2000; salt = 16'h1234;
    pulseReq();
    resetMon(16'h2000);
    pulseFrame();
    waitDone();
    checkFullCopy("R3 one-shot copy");
    salt = 16'hBEEF;  // table updated in memory after the copy
    resetMon(16'h2000);
    pulseFrame();
    cyc(10);
    check(busyCount == 0, "R3 request cleared", 32'(busyCount), 32'd0);
    check(wrCount == 0, "R3 no writes after clear", 32'(wrCount), 32'd0);
  endtask

  task automatic t_reqDuringRun();
    autoMode = 1'b0; baseAddr = 16'h3000; salt = 16'hC3C3;
    pulseReq();
    resetMon(16'h3000);
    pulseFrame();
    cyc(20);
    pulseReq();
    waitDone();
    checkFullCopy("R10 first copy");
    salt = 16'h6666;  // new table contents reach registers only now
    resetMon(16'h3000);
    pulseFrame();
    waitDone();
    checkFullCopy("R10 request kept pending");
    resetMon(16'h3000);
    pulseFrame();
    cyc(10);
    check(busyCount == 0, "R10 pending served once", 32'(busyCount), 32'd0);
  endtask

  task automatic t_frameDuringRun();
    autoMode = 1'b1; baseAddr = 16'h4000; salt = 16'h0101; slotDiv = 1;
    resetMon(16'h4000);
    pulseFrame();
    cyc(50);
    pulseFrame();
    waitDone();
    cyc(10);
    autoMode = 1'b0;
    checkFullCopy("R9 frame end during copy");
    check(busyCount == 258, "R9 no restart", 32'(busyCount), 32'd258);
  endtask

  initial begin
    #1000000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    cyc(3);
    @(negedge clk); #2 rstN = 1'b1;
    @(negedge clk);
    monOn = 1'b1;
    t_reset();
    t_idleFrame();
    t_autoFull();
    t_slowWrap();
    t_oneShot();
    t_reqDuringRun();
    t_frameDuringRun();
    cyc(5);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule